// File: doc/BRIEF.md
# Modulo Pointer Register File

This block holds two banks of operand memory, each paired with a small set of pointer registers. A core asks for an operand by naming a bank, a pointer index and a 2-bit post-modify mode. The block reads the word the chosen pointer addresses and, in the same clock, steps that pointer as the mode asks. The step can be a plain linear increment, or an increment or decrement that wraps inside a power-of-two window. A 3-bit window field, taken from the core's status word, sets the size of that window.

The highest pointer index is not a register. It addresses a fixed cell of the selected bank, and the mode value picks which cell. The core can load any pointer directly, and it can write any memory word through a separate direct port. Data comes back one cycle after the request, flagged by a valid strobe. The current pointer values are always visible on two flat output buses, one for each bank.

Top module: `mptr_regfile`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pointer reads 0 and `rd_valid` is low.
- R2: A request with `rd_en` high returns its word on `rd_data` one cycle later, with `rd_valid` high in that cycle. Without a request, `rd_valid` is low in the next cycle.
- R3: Mode 0 reads the word at the pointer and leaves every pointer unchanged.
- R4: Mode 1 reads the word and then adds 1 to the pointer across all 8 bits, whatever the window field holds. 0xFF steps to 0x00.
- R5: Mode 2 reads and then decrements the pointer. Mode 3 reads and then increments it. With a window field of 0, the step is a plain ±1 modulo 256.
- R6: With a window field n of 1 to 7, modes 2 and 3 only change the low n bits of the pointer, which wrap inside the window. The new pointer is (p & ~m) | ((p ± 1) & m), where m = 2^n − 1.
- R7: Pointer index 3 with mode k reads cell k of the selected bank and changes no pointer.
- R8: The word returned is the one at the pointer's value before the post-modify step.
- R9: A pointer load writes `pw_val` into pointer `pw_idx` of bank `pw_bank`. If a post-modify step targets the same pointer in the same cycle, the load wins.
- R10: A memory write stores `mw_data` at `mw_addr` of bank `mw_bank`. A read of the same word in the same cycle returns the old contents.
- R11: A request on one bank never changes the pointers of the other bank. In the flat buses, pointer i occupies bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Operand request |
| rd_bank | input | 1 | Bank of the request |
| rd_idx | input | 2 | Pointer index; 3 selects a fixed cell |
| rd_mode | input | 2 | Post-modify mode (0 hold, 1 linear inc, 2 window dec, 3 window inc) |
| rd_wsel | input | 3 | Window field from the status word |
| rd_data | output | 16 | Returned word |
| rd_valid | output | 1 | `rd_data` holds the word of the previous request |
| pw_en | input | 1 | Pointer load strobe |
| pw_bank | input | 1 | Bank of the pointer load |
| pw_idx | input | 2 | Pointer to load (0..2) |
| pw_val | input | 8 | Value to load |
| mw_en | input | 1 | Memory write strobe |
| mw_bank | input | 1 | Bank of the memory write |
| mw_addr | input | 8 | Word address of the write |
| mw_data | input | 16 | Data to write |
| ptr_b0 | output | 24 | Bank 0 pointers, flat |
| ptr_b1 | output | 24 | Bank 1 pointers, flat |

## Verification
The checker runs on every cycle. It covers the one-cycle valid timing, that mode 0 and fixed-cell requests keep every pointer, the linear +1 of mode 1, and that the window modes leave the bits above the window untouched. Several behaviours only the bench scenarios can show, because they need a model of the memory contents. These are the data values returned, that the data comes from the pre-step pointer, the exact wrap points at 0xFF/0x00 and at the window edges, which fixed cell each mode selects, that a load wins over a step, and the read-old-data result when a read and a write hit the same word.

// File: rtl/mptr_pkg.sv
// Shared definitions for the modulo pointer register file.
// Assumes a 2-bit post-modify mode code; values are fixed by the core's encoding.
package mptr_pkg;

    typedef enum logic [1:0] {
        MOD_HOLD    = 2'd0,
        MOD_INC_LIN = 2'd1,
        MOD_DEC_WIN = 2'd2,
        MOD_INC_WIN = 2'd3
    } mod_e;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/mptr_step.sv
// Next-pointer arithmetic for one post-modify step.
// Computes the window mask from the status field and applies hold, linear
// increment, or windowed increment/decrement. Purely combinational.
module mptr_step
    import mptr_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int WSEL_W = 3
) (
    input  logic [PTR_W-1:0]  cur,
    input  mod_e              mode,
    input  logic [WSEL_W-1:0] wsel,
    output logic [PTR_W-1:0]  nxt
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] plus1;
    logic [PTR_W-1:0] minus1;

    // Window mask: a zero field means the full pointer width.
    always_comb begin
        if (wsel == '0) mask = '1;
        else            mask = (ONE << wsel) - ONE;
    end

    assign plus1  = cur + ONE;
    assign minus1 = cur - ONE;

    // Select the stepped value for the requested mode.
    always_comb begin
        unique case (mode)
            MOD_HOLD:    nxt = cur;
            MOD_INC_LIN: nxt = plus1;
            MOD_DEC_WIN: nxt = (cur & ~mask) | (minus1 & mask);
            MOD_INC_WIN: nxt = (cur & ~mask) | (plus1 & mask);
            default:     nxt = cur;
        endcase
    end

endmodule

// File: rtl/mptr_ptrs.sv
// Pointer registers of one bank.
// A direct load has priority over a post-modify update of the same pointer.
// Assumes indices at or above NPTR never reach the update or load strobes.
module mptr_ptrs #(
    parameter int PTR_W = 8,
    parameter int NPTR  = 3,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_en,
    input  logic [IDX_W-1:0]      upd_idx,
    input  logic [PTR_W-1:0]      upd_val,
    input  logic                  ld_en,
    input  logic [IDX_W-1:0]      ld_idx,
    input  logic [PTR_W-1:0]      ld_val,
    output logic [NPTR*PTR_W-1:0] ptrs
);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [PTR_W-1:0] p_q;

        // One pointer: reset, load, or post-modify update.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    p_q <= '0;
            else if (ld_en && ld_idx == IDX_W'(g))         p_q <= ld_val;
            else if (upd_en && upd_idx == IDX_W'(g))       p_q <= upd_val;
        end

        assign ptrs[g*PTR_W +: PTR_W] = p_q;
    end

endmodule

// File: rtl/mptr_bank.sv
// One bank of operand memory with a registered read and a direct write port.
// A read and a write to the same word in one cycle return the old word.
module mptr_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read of the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

endmodule

// File: rtl/mptr_regfile.sv
// Modulo pointer register file: two memory banks, each with NPTR pointers.
// The top index value (NPTR) addresses the fixed cell numbered by the mode.
// Returns data one cycle after the request; pointers step at the same edge.
module mptr_regfile
    import mptr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 8,
    parameter int WSEL_W = 3,
    parameter int NPTR   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  rd_bank,
    input  logic [1:0]            rd_idx,
    input  logic [1:0]            rd_mode,
    input  logic [WSEL_W-1:0]     rd_wsel,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    input  logic                  pw_en,
    input  logic                  pw_bank,
    input  logic [1:0]            pw_idx,
    input  logic [PTR_W-1:0]      pw_val,
    input  logic                  mw_en,
    input  logic                  mw_bank,
    input  logic [PTR_W-1:0]      mw_addr,
    input  logic [DATA_W-1:0]     mw_data,
    output logic [NPTR*PTR_W-1:0] ptr_b0,
    output logic [NPTR*PTR_W-1:0] ptr_b1
);

    localparam int IDX_W = 2;

    logic [NPTR*PTR_W-1:0] flat   [NUM_BANKS];
    logic [DATA_W-1:0]     bank_q [NUM_BANKS];
    logic [PTR_W-1:0]      cur_ptr;
    logic [PTR_W-1:0]      nxt_ptr;
    logic [PTR_W-1:0]      rd_addr;
    logic                  fixed_cell;
    logic                  step_en;
    logic                  bank_sel_q;
    mod_e                  mode;

    assign mode       = mod_e'(rd_mode);
    assign fixed_cell = (rd_idx == IDX_W'(NPTR));
    assign step_en    = rd_en && !fixed_cell && (mode != MOD_HOLD);

    // Pick the addressed pointer of the selected bank.
    always_comb begin
        cur_ptr = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (rd_idx == IDX_W'(i)) cur_ptr = flat[rd_bank][i*PTR_W +: PTR_W];
        end
    end

    // Address: pointer value, or the fixed cell named by the mode.
    assign rd_addr = fixed_cell ? PTR_W'(rd_mode) : cur_ptr;

    mptr_step #(
        .PTR_W  (PTR_W),
        .WSEL_W (WSEL_W)
    ) u_step (
        .cur  (cur_ptr),
        .mode (mode),
        .wsel (rd_wsel),
        .nxt  (nxt_ptr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mptr_ptrs #(
            .PTR_W (PTR_W),
            .NPTR  (NPTR),
            .IDX_W (IDX_W)
        ) u_ptrs (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (step_en && (rd_bank == 1'(b))),
            .upd_idx (rd_idx),
            .upd_val (nxt_ptr),
            .ld_en   (pw_en && (pw_bank == 1'(b))),
            .ld_idx  (pw_idx),
            .ld_val  (pw_val),
            .ptrs    (flat[b])
        );

        mptr_bank #(
            .DATA_W (DATA_W),
            .ADDR_W (PTR_W)
        ) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rd_en && (rd_bank == 1'(b))),
            .rd_addr (rd_addr),
            .rd_q    (bank_q[b]),
            .wr_en   (mw_en && (mw_bank == 1'(b))),
            .wr_addr (mw_addr),
            .wr_data (mw_data)
        );
    end

    // Track which bank answers and when the answer is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            bank_sel_q <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) bank_sel_q <= rd_bank;
        end
    end

    assign rd_data = bank_q[bank_sel_q];
    assign ptr_b0  = flat[0];
    assign ptr_b1  = flat[1];

endmodule

// File: rtl/mptr_regfile_chk.sv
// Cycle-by-cycle properties of the modulo pointer register file, bound to the top.
module mptr_regfile_chk #(
    parameter int PTR_W  = 8,
    parameter int WSEL_W = 3,
    parameter int NPTR   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic                  rd_bank,
    input logic [1:0]            rd_idx,
    input logic [1:0]            rd_mode,
    input logic [WSEL_W-1:0]     rd_wsel,
    input logic                  rd_valid,
    input logic                  pw_en,
    input logic [NPTR*PTR_W-1:0] ptr_b0,
    input logic [NPTR*PTR_W-1:0] ptr_b1
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    function automatic logic [PTR_W-1:0] pick(input logic [NPTR*PTR_W-1:0] a,
                                              input logic [NPTR*PTR_W-1:0] b,
                                              input logic bank, input logic [1:0] idx);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = 0; i < NPTR; i++)
            if (idx == 2'(i)) r = bank ? b[i*PTR_W +: PTR_W] : a[i*PTR_W +: PTR_W];
        return r;
    endfunction

    logic [PTR_W-1:0] cur;
    logic [PTR_W-1:0] wmask;
    logic             is_ptr;

    assign cur    = pick(ptr_b0, ptr_b1, rd_bank, rd_idx);
    assign wmask  = (ONE << rd_wsel) - ONE;
    assign is_ptr = (rd_idx != 2'(NPTR));

    // R2: valid strobe follows the request by one cycle.
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R3: hold mode keeps every pointer.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_ptr && rd_mode == 2'd0 && !pw_en) |=> ($stable(ptr_b0) && $stable(ptr_b1)));

    // R4: linear mode adds one across the full width.
    p_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_ptr && rd_mode == 2'd1 && !pw_en) |=>
        (pick(ptr_b0, ptr_b1, $past(rd_bank), $past(rd_idx)) == $past(cur) + ONE));

    // R6: windowed modes keep the bits above the window.
    p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_ptr && rd_mode[1] && rd_wsel != '0 && !pw_en) |=>
        ((pick(ptr_b0, ptr_b1, $past(rd_bank), $past(rd_idx)) & ~$past(wmask)) ==
         ($past(cur) & ~$past(wmask))));

    // R7: fixed-cell access changes no pointer.
    p_fixed_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_ptr && !pw_en) |=> ($stable(ptr_b0) && $stable(ptr_b1)));

endmodule

bind mptr_regfile mptr_regfile_chk #(
    .PTR_W  (PTR_W),
    .WSEL_W (WSEL_W),
    .NPTR   (NPTR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_bank  (rd_bank),
    .rd_idx   (rd_idx),
    .rd_mode  (rd_mode),
    .rd_wsel  (rd_wsel),
    .rd_valid (rd_valid),
    .pw_en    (pw_en),
    .ptr_b0   (ptr_b0),
    .ptr_b1   (ptr_b1)
);

// File: tb/mptr_regfile_bench.sv
// Scoreboard bench: the driver queues expected words, the monitor compares them.
module mptr_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 0, rd_bank = 0;
    logic [1:0]  rd_idx = 0, rd_mode = 0;
    logic [2:0]  rd_wsel = 0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        pw_en = 0, pw_bank = 0;
    logic [1:0]  pw_idx = 0;
    logic [7:0]  pw_val = 0;
    logic        mw_en = 0, mw_bank = 0;
    logic [7:0]  mw_addr = 0;
    logic [15:0] mw_data = 0;
    logic [23:0] ptr_b0, ptr_b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] mem_m [2][256];
    logic [7:0]  ptr_m [2][3];

    always #5 clk = ~clk;

    mptr_regfile u_mptr_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_mode(rd_mode), .rd_wsel(rd_wsel),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .pw_en(pw_en), .pw_bank(pw_bank), .pw_idx(pw_idx), .pw_val(pw_val),
        .mw_en(mw_en), .mw_bank(mw_bank), .mw_addr(mw_addr), .mw_data(mw_data),
        .ptr_b0(ptr_b0), .ptr_b1(ptr_b1)
    );

    function automatic logic [15:0] init_word(input bit b, input int a);
        return {b ? 8'hB1 : 8'hA0, 8'(a)};
    endfunction

    // Expected step from the requirement formulas (R4, R5, R6).
    function automatic logic [7:0] m_next(input logic [7:0] p, input logic [1:0] m,
                                          input logic [2:0] f);
        logic [7:0] mk;
        mk = (f == 0) ? 8'hFF : 8'((1 << f) - 1);
        case (m)
            2'd0: return p;
            2'd1: return p + 8'd1;
            2'd2: return (p & ~mk) | ((p - 8'd1) & mk);
            default: return (p & ~mk) | ((p + 8'd1) & mk);
        endcase
    endfunction

    task automatic check_ptrs(input string tag);
        logic [23:0] e0, e1;
        for (int i = 0; i < 3; i++) begin
            e0[i*8 +: 8] = ptr_m[0][i];
            e1[i*8 +: 8] = ptr_m[1][i];
        end
        checks++;
        if (ptr_b0 !== e0 || ptr_b1 !== e1) begin
            fails++;
            $display("FAIL %s pointers: actual %h/%h expected %h/%h", tag, ptr_b1, ptr_b0, e1, e0);
        end
    endtask

    // Driver: one cycle of stimulus; models the result and queues the expected word.
    task automatic op(input string tag, input bit ren, input bit rb, input logic [1:0] ri,
                      input logic [1:0] rm, input logic [2:0] rf,
                      input bit pwe, input bit pwb, input logic [1:0] pwi, input logic [7:0] pwv,
                      input bit mwe, input bit mwb, input logic [7:0] mwa, input logic [15:0] mwd);
        logic [7:0] a;
        if (ren) begin
            a = (ri == 2'd3) ? {6'd0, rm} : ptr_m[rb][ri];
            exp_q.push_back(mem_m[rb][a]);
            tag_q.push_back(tag);
            if (ri != 2'd3) ptr_m[rb][ri] = m_next(ptr_m[rb][ri], rm, rf);
        end
        if (pwe) ptr_m[pwb][pwi] = pwv;
        if (mwe) mem_m[mwb][mwa] = mwd;
        rd_en = ren; rd_bank = rb; rd_idx = ri; rd_mode = rm; rd_wsel = rf;
        pw_en = pwe; pw_bank = pwb; pw_idx = pwi; pw_val = pwv;
        mw_en = mwe; mw_bank = mwb; mw_addr = mwa; mw_data = mwd;
        @(negedge clk);
        rd_en = 0; pw_en = 0; mw_en = 0;
        check_ptrs(tag);
    endtask

    task automatic rd(input string tag, input bit b, input logic [1:0] i,
                      input logic [1:0] m, input logic [2:0] f);
        op(tag, 1, b, i, m, f, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic pset(input string tag, input bit b, input logic [1:0] i, input logic [7:0] v);
        op(tag, 0, 0, 0, 0, 0, 1, b, i, v, 0, 0, 0, 0);
    endtask

    // Monitor: compare each returned word with the head of the queue (R2, R8).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected valid: actual %h expected none", rd_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s data: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 3; i++) ptr_m[b][i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state.
        checks++;
        if (ptr_b0 !== 24'h0 || ptr_b1 !== 24'h0 || rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual %h/%h v=%b expected 0/0 v=0", ptr_b1, ptr_b0, rd_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_ptrs("R1");
        // Fill both banks through the direct write port (R10).
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 256; a++) begin
                mem_m[b][a] = init_word(b[0], a);
                mw_en = 1; mw_bank = b[0]; mw_addr = 8'(a); mw_data = init_word(b[0], a);
                @(negedge clk);
            end
        mw_en = 0;

        pset("R9", 0, 0, 8'h10);
        rd("R3", 0, 0, 2'd0, 3'd0);            // A010, pointer stays 0x10
        rd("R4", 0, 0, 2'd1, 3'd3);            // A010, pointer 0x11 despite window field
        rd("R8", 0, 0, 2'd0, 3'd0);            // A011
        pset("R9", 0, 0, 8'hFF);
        rd("R4", 0, 0, 2'd1, 3'd0);            // A0FF, wraps to 0x00
        pset("R9", 0, 1, 8'hFF);
        rd("R5", 0, 1, 2'd3, 3'd0);            // A0FF, 0xFF -> 0x00
        rd("R5", 0, 1, 2'd2, 3'd0);            // A000, 0x00 -> 0xFF
        pset("R9", 1, 2, 8'h17);
        rd("R6", 1, 2, 2'd3, 3'd2);            // B117, 0x17 -> 0x14
        rd("R6", 1, 2, 2'd2, 3'd2);            // B114, 0x14 -> 0x17
        pset("R9", 1, 0, 8'h7F);
        rd("R6", 1, 0, 2'd3, 3'd7);            // B17F, 0x7F -> 0x00
        pset("R9", 1, 0, 8'hFF);
        rd("R6", 1, 0, 2'd3, 3'd7);            // B1FF, 0xFF -> 0x80
        rd("R6", 1, 0, 2'd2, 3'd1);            // B180, 0x80 -> 0x81
        rd("R7", 1, 2'd3, 2'd2, 3'd0);         // B102, no pointer change
        rd("R7", 0, 2'd3, 2'd0, 3'd5);         // A000
        rd("R11", 0, 1, 2'd3, 3'd0);           // bank 1 pointers unchanged
        // R9: load wins over a post-modify of the same pointer.
        pset("R9", 1, 1, 8'h40);
        op("R9", 1, 1, 2'd1, 2'd1, 3'd0, 1, 1, 2'd1, 8'h77, 0, 0, 0, 0);
        // R10: same-cycle read and write of cell 1 returns the old word.
        op("R10", 1, 0, 2'd3, 2'd1, 3'd0, 0, 0, 0, 0, 1, 0, 8'h01, 16'h1234);
        rd("R10", 0, 2'd3, 2'd1, 3'd0);        // now 1234
        // Back-to-back requests (R2).
        rd_en = 1; rd_bank = 0; rd_idx = 0; rd_mode = 2'd3; rd_wsel = 3'd0;
        exp_q.push_back(mem_m[0][ptr_m[0][0]]); tag_q.push_back("R2");
        ptr_m[0][0] = m_next(ptr_m[0][0], 2'd3, 3'd0);
        @(negedge clk);
        exp_q.push_back(mem_m[0][ptr_m[0][0]]); tag_q.push_back("R2");
        ptr_m[0][0] = m_next(ptr_m[0][0], 2'd3, 3'd0);
        @(negedge clk);
        rd_en = 0;
        check_ptrs("R2");
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || rd_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2 drain: actual %0d pending v=%b expected 0 pending v=0",
                     exp_q.size(), rd_valid);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule